// File: doc/BRIEF.md
# Prioritized Interrupt Entry and Return Sequencer

This block sits next to a small processor core and runs the memory traffic for interrupt entry and for return from an interrupt handler. Several devices raise level requests, each with a 3-bit priority. The block picks one winner and compares it with the priority field of the core's live status word. When the winner is accepted, the block saves the status word and the program counter on a descending memory stack. It then reads the handler address and a fresh status word from that device's two-word vector and hands both to the core in a one-cycle load strobe. A software trap strobe takes the same path through one fixed vector and is not subject to the priority check.

A return strobe reverses the entry. The block pops the program counter and then the status word, and delivers both through the same load strobe. Because the status word taken from a vector sets a new priority, nested interrupts need no extra logic. Only a request with a higher priority than the running handler can break in. The stack pointer lives inside the block and starts at a parameterised value. All traffic goes through one single-word memory port, which makes one access per cycle and returns read data combinationally.

Top module: `intr_seq`

## Requirements
- R1: After reset, busy, load_valid, mem_req and every irq_ack bit are 0, and the internal stack pointer holds SP_INIT.
- R2: A device request is accepted only when its priority is strictly greater than cur_psw[7:5]. An equal or lower priority leaves the block idle with no acknowledge.
- R3: On entry the block writes the saved status word at SP-2 and then the saved PC at SP-4, in two consecutive cycles, leaving SP lowered by 4.
- R4: Device i's vector sits at VEC_BASE+4*i. The block reads the handler PC from the vector address and the new status word from the vector address+2. In the following cycle it raises load_valid for one cycle with new_pc and new_psw holding those two words.
- R5: Among pending requests the highest priority wins, and the lowest device index breaks a tie. irq_ack is one-hot for exactly one cycle, in the first cycle of the sequence.
- R6: trap_req starts an entry through the fixed vector TRAP_VEC whatever the current priority. No irq_ack bit rises for a trap.
- R7: rti_req pops the PC from SP and then the status word from SP+2, leaving SP raised by 4. load_valid then presents both words.
- R8: Level requests that arrive during a sequence are held and evaluated in the first idle cycle afterwards. trap_req and rti_req pulses that arrive while busy have no effect.
- R9: busy is high from the first access of a sequence through its load cycle: 5 cycles for entry and 3 for return. mem_req is never high while busy is low.
- R10: When several start conditions are present in one idle cycle, rti_req has precedence over trap_req, which has precedence over device requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_DEV | Level interrupt requests, one per device |
| irq_pri | input | N_DEV*PW | Packed per-device priorities, device i at [i*PW +: PW] |
| irq_ack | output | N_DEV | One-cycle one-hot grant to the accepted device |
| trap_req | input | 1 | Software trap strobe (fixed vector) |
| rti_req | input | 1 | Return-from-interrupt strobe |
| cur_psw | input | W | Live status word; priority at bits [7:5] |
| cur_pc | input | W | Live program counter to save on entry |
| busy | output | 1 | A sequence is in progress |
| load_valid | output | 1 | Core should load new_pc and new_psw this cycle |
| new_pc | output | W | Program counter to load |
| new_psw | output | W | Status word to load |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | W | Byte address of the word |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid in the same cycle |

## Verification
The bench checks a request whose priority equals the current priority. A comparison that used greater-or-equal would wrongly start a nested entry there. It raises two requests of equal top priority along with a weaker one, so an arbiter that favoured the higher index or ignored priority would acknowledge the wrong device and fetch the wrong vector. It pushes two nested levels and unwinds them, so a swapped push order or a wrong pointer step would hand back a wrong PC or status word. Trap and return strobes are pulsed during a sequence, and both are pulsed together, to show that a busy strobe is dropped and that return beats trap.

// File: rtl/intr_pkg.sv
package intr_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PUSH_PSW,
        SQ_PUSH_PC,
        SQ_FETCH_PC,
        SQ_FETCH_PSW,
        SQ_POP_PC,
        SQ_POP_PSW,
        SQ_LOAD
    } seq_state_e;

endpackage

// File: rtl/intr_arb.sv
module intr_arb #(
    parameter int N_DEV = 4,
    parameter int PW    = 3,
    localparam int IW   = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic [N_DEV-1:0]    req,
    input  logic [N_DEV*PW-1:0] pri,
    output logic                win_valid,
    output logic [IW-1:0]       win_idx,
    output logic [PW-1:0]       win_pri
);

    logic [PW-1:0] pri_a [N_DEV];

    for (genvar g = 0; g < N_DEV; g++) begin : g_slice
        assign pri_a[g] = pri[g*PW +: PW];
    end

    // Scan from the top index down with >=, so a lower index wins a tie.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_pri   = '0;
        for (int i = N_DEV - 1; i >= 0; i--) begin
            if (req[i] && (!win_valid || pri_a[i] >= win_pri)) begin
                win_valid = 1'b1;
                win_idx   = IW'(i);
                win_pri   = pri_a[i];
            end
        end
    end

    always_comb begin
        if (win_valid) begin
            assert_win_req_R5: assert (req[win_idx]);
        end
    end

endmodule

// File: rtl/intr_vec.sv
module intr_vec #(
    parameter int           N_DEV    = 4,
    parameter int           W        = 16,
    parameter logic [W-1:0] VEC_BASE = 16'h0040,
    parameter logic [W-1:0] TRAP_VEC = 16'h001C,
    localparam int          IW       = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic          is_trap,
    input  logic [IW-1:0] idx,
    output logic [W-1:0]  vec_addr
);

    // Each device vector is two words (4 bytes) long.
    always_comb begin
        if (is_trap) vec_addr = TRAP_VEC;
        else         vec_addr = VEC_BASE + (W'(idx) << 2);
    end

endmodule

// File: rtl/intr_seq.sv
module intr_seq
    import intr_pkg::*;
#(
    parameter int           N_DEV    = 4,
    parameter int           W        = 16,
    parameter int           PW       = 3,
    parameter int           PRI_LSB  = 5,
    parameter logic [W-1:0] SP_INIT  = 16'h0200,
    parameter logic [W-1:0] VEC_BASE = 16'h0040,
    parameter logic [W-1:0] TRAP_VEC = 16'h001C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_DEV-1:0]    irq_req,
    input  logic [N_DEV*PW-1:0] irq_pri,
    output logic [N_DEV-1:0]    irq_ack,
    input  logic                trap_req,
    input  logic                rti_req,
    input  logic [W-1:0]        cur_psw,
    input  logic [W-1:0]        cur_pc,
    output logic                busy,
    output logic                load_valid,
    output logic [W-1:0]        new_pc,
    output logic [W-1:0]        new_psw,
    output logic                mem_req,
    output logic                mem_we,
    output logic [W-1:0]        mem_addr,
    output logic [W-1:0]        mem_wdata,
    input  logic [W-1:0]        mem_rdata
);

    localparam int          IW   = (N_DEV > 1) ? $clog2(N_DEV) : 1;
    localparam logic [W-1:0] STEP = W'(2);

    typedef struct packed {
        seq_state_e       state;
        logic [W-1:0]     sp;
        logic [W-1:0]     save_psw;
        logic [W-1:0]     save_pc;
        logic [W-1:0]     vec;
        logic [W-1:0]     npc;
        logic [W-1:0]     npsw;
        logic [N_DEV-1:0] ack;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic          win_valid;
    logic [IW-1:0] win_idx;
    logic [PW-1:0] win_pri;
    logic [W-1:0]  vec_addr;
    logic          accept;

    intr_arb #(.N_DEV(N_DEV), .PW(PW)) u_arb (
        .req       (irq_req),
        .pri       (irq_pri),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_pri   (win_pri)
    );

    intr_vec #(
        .N_DEV    (N_DEV),
        .W        (W),
        .VEC_BASE (VEC_BASE),
        .TRAP_VEC (TRAP_VEC)
    ) u_vec (
        .is_trap  (trap_req),
        .idx      (win_idx),
        .vec_addr (vec_addr)
    );

    assign accept = win_valid && (win_pri > cur_psw[PRI_LSB +: PW]);

    // Next-state process
    always_comb begin
        r_d     = r_q;
        r_d.ack = '0;
        unique case (r_q.state)
            SQ_IDLE: begin
                if (rti_req) begin
                    r_d.state = SQ_POP_PC;
                end else if (trap_req) begin
                    r_d.save_psw = cur_psw;
                    r_d.save_pc  = cur_pc;
                    r_d.vec      = vec_addr;
                    r_d.state    = SQ_PUSH_PSW;
                end else if (accept) begin
                    r_d.save_psw = cur_psw;
                    r_d.save_pc  = cur_pc;
                    r_d.vec      = vec_addr;
                    r_d.ack      = N_DEV'(1) << win_idx;
                    r_d.state    = SQ_PUSH_PSW;
                end
            end
            SQ_PUSH_PSW: begin
                r_d.sp    = r_q.sp - STEP;
                r_d.state = SQ_PUSH_PC;
            end
            SQ_PUSH_PC: begin
                r_d.sp    = r_q.sp - STEP;
                r_d.state = SQ_FETCH_PC;
            end
            SQ_FETCH_PC: begin
                r_d.npc   = mem_rdata;
                r_d.state = SQ_FETCH_PSW;
            end
            SQ_FETCH_PSW: begin
                r_d.npsw  = mem_rdata;
                r_d.state = SQ_LOAD;
            end
            SQ_POP_PC: begin
                r_d.npc   = mem_rdata;
                r_d.sp    = r_q.sp + STEP;
                r_d.state = SQ_POP_PSW;
            end
            SQ_POP_PSW: begin
                r_d.npsw  = mem_rdata;
                r_d.sp    = r_q.sp + STEP;
                r_d.state = SQ_LOAD;
            end
            SQ_LOAD: begin
                r_d.state = SQ_IDLE;
            end
            default: r_d.state = SQ_IDLE;
        endcase
    end

    // Register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state    <= SQ_IDLE;
            r_q.sp       <= SP_INIT;
            r_q.save_psw <= '0;
            r_q.save_pc  <= '0;
            r_q.vec      <= '0;
            r_q.npc      <= '0;
            r_q.npsw     <= '0;
            r_q.ack      <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // Memory port drive
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.sp;
        mem_wdata = '0;
        unique case (r_q.state)
            SQ_PUSH_PSW: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.sp - STEP;
                mem_wdata = r_q.save_psw;
            end
            SQ_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.sp - STEP;
                mem_wdata = r_q.save_pc;
            end
            SQ_FETCH_PC: begin
                mem_req  = 1'b1;
                mem_addr = r_q.vec;
            end
            SQ_FETCH_PSW: begin
                mem_req  = 1'b1;
                mem_addr = r_q.vec + STEP;
            end
            SQ_POP_PC, SQ_POP_PSW: begin
                mem_req  = 1'b1;
                mem_addr = r_q.sp;
            end
            default: ;
        endcase
    end

    assign busy       = (r_q.state != SQ_IDLE);
    assign load_valid = (r_q.state == SQ_LOAD);
    assign new_pc     = r_q.npc;
    assign new_psw    = r_q.npsw;
    assign irq_ack    = r_q.ack;

    assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack));

    assert_ack_had_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_ack) |-> (($past(irq_req) & irq_ack) != '0));

    assert_push_descends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && $past(mem_req && mem_we)) |->
            (mem_addr == $past(mem_addr) - STEP));

    assert_load_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |=> !busy);

    assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

endmodule

// File: tb/sim_intr_seq.sv
`timescale 1ns/1ps
module sim_intr_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  irq_req;
    logic [11:0] irq_pri;
    logic [3:0]  irq_ack;
    logic        trap_req, rti_req;
    logic [15:0] cpu_psw, cpu_pc;
    logic        busy, load_valid;
    logic [15:0] new_pc, new_psw;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;

    logic [15:0] mem [0:511];
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    logic [15:0] sp_m;

    always #2 clk = ~clk;

    intr_seq u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_pri(irq_pri),
        .irq_ack(irq_ack), .trap_req(trap_req), .rti_req(rti_req),
        .cur_psw(cpu_psw), .cur_pc(cpu_pc), .busy(busy), .load_valid(load_valid),
        .new_pc(new_pc), .new_psw(new_psw), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[9:1]];
    always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[9:1]] <= mem_wdata;

    // Core model: loads PC and status word on the strobe.
    always @(posedge clk) if (load_valid) begin
        cpu_pc  <= new_pc;
        cpu_psw <= new_psw;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic set_pri(input logic [2:0] p0, p1, p2, p3);
        irq_pri = {p3, p2, p1, p0};
    endtask

    task automatic set_cpu(input logic [15:0] psw, pc);
        @(negedge clk);
        cpu_psw = psw;
        cpu_pc  = pc;
    endtask

    // Caller raises the start condition at a negedge, then calls this.
    task automatic expect_entry(input string tag, input int dev,
                                input logic [15:0] psw, pc, vec, npc, npsw,
                                input bit inject);
        @(negedge clk);
        chk({tag, " R5 ack"}, {12'h0, irq_ack}, (dev < 0) ? 16'h0 : (16'h1 << dev));
        chk({tag, " R9 busy"}, {15'h0, busy}, 16'h1);
        chk({tag, " R3 we1"}, {15'h0, mem_we}, 16'h1);
        chk({tag, " R3 addr1"}, mem_addr, sp_m - 16'h2);
        chk({tag, " R3 psw"}, mem_wdata, psw);
        if (dev >= 0) irq_req[dev] = 1'b0;
        trap_req = 1'b0;
        if (inject) begin
            trap_req   = 1'b1;
            rti_req    = 1'b1;
            irq_req[0] = 1'b1;
        end
        @(negedge clk);
        chk({tag, " R5 ack low"}, {12'h0, irq_ack}, 16'h0);
        chk({tag, " R3 we2"}, {15'h0, mem_we}, 16'h1);
        chk({tag, " R3 addr2"}, mem_addr, sp_m - 16'h4);
        chk({tag, " R3 pc"}, mem_wdata, pc);
        trap_req = 1'b0;
        rti_req  = 1'b0;
        @(negedge clk);
        chk({tag, " R4 vec pc addr"}, mem_addr, vec);
        chk({tag, " R4 read"}, {14'h0, mem_req, mem_we}, 16'h2);
        @(negedge clk);
        chk({tag, " R4 vec psw addr"}, mem_addr, vec + 16'h2);
        @(negedge clk);
        chk({tag, " R4 load"}, {15'h0, load_valid}, 16'h1);
        chk({tag, " R4 new_pc"}, new_pc, npc);
        chk({tag, " R4 new_psw"}, new_psw, npsw);
        @(negedge clk);
        chk({tag, " R9 idle"}, {15'h0, busy}, 16'h0);
        chk({tag, " R4 core pc"}, cpu_pc, npc);
        sp_m = sp_m - 16'h4;
    endtask

    task automatic expect_return(input string tag, input logic [15:0] pc, psw);
        @(negedge clk);
        rti_req  = 1'b0;
        trap_req = 1'b0;
        chk({tag, " R7 pop1"}, {14'h0, mem_req, mem_we}, 16'h2);
        chk({tag, " R7 addr1"}, mem_addr, sp_m);
        @(negedge clk);
        chk({tag, " R7 addr2"}, mem_addr, sp_m + 16'h2);
        @(negedge clk);
        chk({tag, " R7 load"}, {15'h0, load_valid}, 16'h1);
        chk({tag, " R7 pc"}, new_pc, pc);
        chk({tag, " R7 psw"}, new_psw, psw);
        @(negedge clk);
        chk({tag, " R9 idle"}, {15'h0, busy}, 16'h0);
        sp_m = sp_m + 16'h4;
    endtask

    task automatic t_reset;
        chk("R1 busy", {15'h0, busy}, 16'h0);
        chk("R1 ack", {12'h0, irq_ack}, 16'h0);
        chk("R1 mem_req", {15'h0, mem_req}, 16'h0);
        chk("R1 load", {15'h0, load_valid}, 16'h0);
    endtask

    task automatic t_basic_and_nest;
        set_cpu(16'h0000, 16'h0100);
        set_pri(3'd0, 3'd0, 3'd4, 3'd0);
        irq_req[2] = 1'b1;
        expect_entry("R2 basic", 2, 16'h0000, 16'h0100, 16'h0048, 16'h2200, 16'h00A0, 0);
        // equal priority 5 vs psw priority 5: must stay idle
        set_pri(3'd0, 3'd5, 3'd4, 3'd0);
        irq_req[1] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R2 equal busy", {15'h0, busy}, 16'h0);
            chk("R2 equal ack", {12'h0, irq_ack}, 16'h0);
        end
        irq_req[1] = 1'b0;
        set_pri(3'd6, 3'd5, 3'd4, 3'd0);
        irq_req[0] = 1'b1;
        expect_entry("R2 nested", 0, 16'h00A0, 16'h2200, 16'h0040, 16'h2000, 16'h00E0, 0);
        rti_req = 1'b1;
        expect_return("R7 ret1", 16'h2200, 16'h00A0);
        rti_req = 1'b1;
        expect_return("R7 ret2", 16'h0100, 16'h0000);
    endtask

    task automatic t_arbitrate;
        set_cpu(16'h0000, 16'h0300);
        set_pri(3'd0, 3'd1, 3'd6, 3'd6);
        irq_req = 4'b1110;
        expect_entry("R5 tie", 2, 16'h0000, 16'h0300, 16'h0048, 16'h2200, 16'h00A0, 0);
        // dev3 (pri 6) is still pending and beats new priority 5
        expect_entry("R8 follow", 3, 16'h00A0, 16'h2200, 16'h004C, 16'h2300, 16'h0040, 0);
        irq_req[1] = 1'b0;
        rti_req = 1'b1;
        expect_return("R7 arb ret1", 16'h2200, 16'h00A0);
        rti_req = 1'b1;
        expect_return("R7 arb ret2", 16'h0300, 16'h0000);
    endtask

    task automatic t_trap;
        set_cpu(16'h00E0, 16'h0400);
        trap_req = 1'b1;
        expect_entry("R6 trap", -1, 16'h00E0, 16'h0400, 16'h001C, 16'h1C00, 16'h00E0, 0);
        rti_req = 1'b1;
        expect_return("R6 trap ret", 16'h0400, 16'h00E0);
    endtask

    task automatic t_busy_hold;
        set_cpu(16'h0000, 16'h0500);
        set_pri(3'd7, 3'd0, 3'd0, 3'd2);
        irq_req[3] = 1'b1;
        expect_entry("R8 inject", 3, 16'h0000, 16'h0500, 16'h004C, 16'h2300, 16'h0040, 1);
        // held dev0 request taken next; SP proves the busy strobes were dropped
        expect_entry("R8 held", 0, 16'h0040, 16'h2300, 16'h0040, 16'h2000, 16'h00E0, 0);
        rti_req = 1'b1;
        expect_return("R8 ret1", 16'h2300, 16'h0040);
        rti_req = 1'b1;
        expect_return("R8 ret2", 16'h0500, 16'h0000);
    endtask

    task automatic t_precedence;
        set_cpu(16'h0000, 16'h0600);
        set_pri(3'd0, 3'd3, 3'd0, 3'd0);
        trap_req   = 1'b1;
        irq_req[1] = 1'b1;
        expect_entry("R10 trap>irq", -1, 16'h0000, 16'h0600, 16'h001C, 16'h1C00, 16'h00E0, 0);
        rti_req  = 1'b1;
        trap_req = 1'b1;
        expect_return("R10 rti>trap", 16'h0600, 16'h0000);
        expect_entry("R10 irq after", 1, 16'h0000, 16'h0600, 16'h0044, 16'h2100, 16'h0060, 0);
        rti_req = 1'b1;
        expect_return("R10 ret", 16'h0600, 16'h0000);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = 16'h0;
        for (int i = 0; i < 4; i++) mem[(16'h40 + 4*i) >> 1] = 16'h2000 + 16'h100 * i;
        mem[16'h42 >> 1] = 16'h00E0;
        mem[16'h46 >> 1] = 16'h0060;
        mem[16'h4A >> 1] = 16'h00A0;
        mem[16'h4E >> 1] = 16'h0040;
        mem[16'h1C >> 1] = 16'h1C00;
        mem[16'h1E >> 1] = 16'h00E0;
        rst_n    = 1'b0;
        irq_req  = '0;
        irq_pri  = '0;
        trap_req = 1'b0;
        rti_req  = 1'b0;
        cpu_psw  = '0;
        cpu_pc   = '0;
        sp_m     = 16'h0200;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_and_nest();
        t_arbitrate();
        t_trap();
        t_busy_hold();
        t_precedence();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule